// File: doc/BRIEF.md
# Process-ID TLB Flush Scanner

This engine runs when software asks for every translation that belongs to one process to be dropped. A single start pulse latches an 8-bit process ID. The engine then reads, one by one, all entries of the instruction TLB and the data TLB through a synchronous read port. It judges each entry and, for every entry that qualifies, offers a page-invalidate request. The request uses a valid/ready handshake and carries the entry's virtual page address. A one-cycle done pulse marks the end of the walk. The caches or maps that act on the requests are outside the block.

An entry qualifies when it is valid and not global, and either its process ID equals the latched one or its kernel bit is set. Global entries always survive. Kernel-protected entries that are not global are swept out whatever process they carry.

The controller is a five-state machine:

- `SC_IDLE` waits for start.
- `SC_FETCH` drives one read address.
- `SC_JUDGE` evaluates the returned words.
- `SC_OFFER` holds a request until it is accepted.
- `SC_DONE` raises the done pulse.

Its transitions are:

- start (`SC_IDLE` to `SC_FETCH`)
- read issued (`SC_FETCH` to `SC_JUDGE`)
- hit (`SC_JUDGE` to `SC_OFFER`)
- miss-next (`SC_JUDGE` to `SC_FETCH`)
- miss-last (`SC_JUDGE` to `SC_DONE`)
- accept-next (`SC_OFFER` to `SC_FETCH`)
- accept-last (`SC_OFFER` to `SC_DONE`)
- release (`SC_DONE` to `SC_IDLE`)

Top module: `pid_flush_scanner`

## Requirements
- R1: Out of reset no read is requested, no flush request is valid and done is low, and this stays so until a start pulse is seen.
- R2: A start pulse seen while idle latches `pid_i`, and this value is used for the whole walk; later changes on `pid_i` do not alter the results.
- R3: One walk issues exactly 128 reads, in the order TLB select outermost (0 = instruction, 1 = data), then way 0..3, then set 0..15 innermost. The read data appears on the hi/lo inputs one cycle after `tlb_rd_en_o`.
- R4: The entry fields are decoded as follows. The hi word bits 7:0 hold the entry's process ID. The lo word bit 4 is global, bit 3 is valid and bit 2 is kernel. An entry produces exactly one flush request when valid=1, global=0, and (process ID equals the latched ID or kernel=1). Requests leave in scan order.
- R5: The flush address is hi bits 31:13 with bits 12:0 forced to zero.
- R6: A valid request keeps its address stable until `flush_ready_i` is seen. No read is issued while a request is pending.
- R7: A start pulse during a walk is ignored: it neither restarts the walk nor starts another one afterwards.
- R8: Done is high for exactly one cycle after the last entry has been judged and its request accepted, once per walk.
- R9: A global entry is never flushed, even when its process ID matches and its kernel bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Flush request pulse |
| pid_i | input | 8 | Process ID to flush |
| tlb_rd_en_o | output | 1 | TLB read strobe |
| tlb_rd_sel_o | output | 1 | TLB select, 0 instruction, 1 data |
| tlb_rd_way_o | output | 2 | Way to read |
| tlb_rd_set_o | output | 4 | Set index to read |
| tlb_rd_hi_i | input | 32 | Entry hi word, one cycle after strobe |
| tlb_rd_lo_i | input | 32 | Entry lo word, one cycle after strobe |
| flush_valid_o | output | 1 | Page-invalidate request valid |
| flush_ready_i | input | 1 | Downstream accepts request |
| flush_addr_o | output | 32 | Page address to invalidate |
| done_o | output | 1 | One-cycle end-of-walk pulse |

## Verification
The assertions assume that the TLB array answers every read strobe exactly one cycle later. They also assume that `flush_ready_i` may be held low for any length of time without the block misbehaving. The bench array model registers its data on the strobe, which keeps the first assumption true. The ready driver switches between always-ready, a pseudo-random pattern and long low stretches, so that stalls both with and without back-pressure are covered. Start pulses and changes on `pid_i` are injected in the middle of a walk only to probe R2 and R7.

// File: rtl/flush_scan_pkg.sv
package flush_scan_pkg;

    typedef enum logic [2:0] {
        SC_IDLE,
        SC_FETCH,
        SC_JUDGE,
        SC_OFFER,
        SC_DONE
    } scan_state_e;

    // Field positions shared with the lookup path
    localparam int LO_GLOBAL_BIT = 4;
    localparam int LO_VALID_BIT  = 3;
    localparam int LO_KERNEL_BIT = 2;
    localparam int HI_PID_LSB    = 0;

    typedef struct packed {
        logic valid;
        logic global_map;
        logic kernel;
    } entry_flags_t;

endpackage

// File: rtl/flush_index_walker.sv
module flush_index_walker #(
    parameter int NUM_TLBS = 2,
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    localparam int TLB_W = (NUM_TLBS > 1) ? $clog2(NUM_TLBS) : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [TLB_W-1:0] tlb_o,
    output logic [WAY_W-1:0] way_o,
    output logic [SET_W-1:0] set_o,
    output logic             last_o
);
    localparam logic [TLB_W-1:0] TLB_MAX = TLB_W'(NUM_TLBS - 1);
    localparam logic [WAY_W-1:0] WAY_MAX = WAY_W'(NUM_WAYS - 1);
    localparam logic [SET_W-1:0] SET_MAX = SET_W'(NUM_SETS - 1);

    logic [TLB_W-1:0] tlb_q;
    logic [WAY_W-1:0] way_q;
    logic [SET_W-1:0] set_q;
    logic set_wrap, way_wrap;

    assign set_wrap = (set_q == SET_MAX);
    assign way_wrap = (way_q == WAY_MAX);

    // Set index is the innermost digit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= '0;
        end else if (clear_i) begin
            set_q <= '0;
        end else if (step_i) begin
            set_q <= set_wrap ? '0 : set_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            way_q <= '0;
        end else if (clear_i) begin
            way_q <= '0;
        end else if (step_i && set_wrap) begin
            way_q <= way_wrap ? '0 : way_q + 1'b1;
        end
    end

    // TLB select is the outermost digit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tlb_q <= '0;
        end else if (clear_i) begin
            tlb_q <= '0;
        end else if (step_i && set_wrap && way_wrap) begin
            tlb_q <= (tlb_q == TLB_MAX) ? '0 : tlb_q + 1'b1;
        end
    end

    assign tlb_o  = tlb_q;
    assign way_o  = way_q;
    assign set_o  = set_q;
    assign last_o = set_wrap && way_wrap && (tlb_q == TLB_MAX);

    // R3
    walker_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (tlb_q == '0 && way_q == '0 && set_q == '0));

    // R3
    walker_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && !last_o) |=> !$stable({tlb_q, way_q, set_q}));

endmodule

// File: rtl/flush_entry_judge.sv
module flush_entry_judge
    import flush_scan_pkg::*;
#(
    parameter int PID_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 13
) (
    input  logic [ADDR_W-1:0] hi_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] page_addr_o
);
    entry_flags_t       flags;
    logic [PID_W-1:0]   entry_pid;
    logic               pid_same;

    always_comb begin
        flags.valid      = lo_i[LO_VALID_BIT];
        flags.global_map = lo_i[LO_GLOBAL_BIT];
        flags.kernel     = lo_i[LO_KERNEL_BIT];
        entry_pid        = hi_i[HI_PID_LSB +: PID_W];
        pid_same         = (entry_pid == pid_i);
        hit_o            = flags.valid && !flags.global_map && (pid_same || flags.kernel);
        page_addr_o      = {hi_i[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/flush_req_slot.sv
module flush_req_slot #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            addr_q  <= addr_i;
        end else if (valid_q && ready_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;
    assign addr_o  = addr_q;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ready_i) |=> (valid_q && $stable(addr_q)));

    // R5
    req_page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (addr_q[PAGE_SHIFT-1:0] == '0));

endmodule

// File: rtl/pid_flush_scanner.sv
module pid_flush_scanner
    import flush_scan_pkg::*;
#(
    parameter int NUM_TLBS   = 2,
    parameter int NUM_WAYS   = 4,
    parameter int NUM_SETS   = 16,
    parameter int PID_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 13,
    localparam int TLB_W = (NUM_TLBS > 1) ? $clog2(NUM_TLBS) : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic              tlb_rd_en_o,
    output logic [TLB_W-1:0]  tlb_rd_sel_o,
    output logic [WAY_W-1:0]  tlb_rd_way_o,
    output logic [SET_W-1:0]  tlb_rd_set_o,
    input  logic [ADDR_W-1:0] tlb_rd_hi_i,
    input  logic [ADDR_W-1:0] tlb_rd_lo_i,
    output logic              flush_valid_o,
    input  logic              flush_ready_i,
    output logic [ADDR_W-1:0] flush_addr_o,
    output logic              done_o
);
    scan_state_e state_q, state_d;
    logic [PID_W-1:0]  pid_q;
    logic              walk_clear, walk_step, walk_last;
    logic              entry_hit;
    logic [ADDR_W-1:0] entry_addr;
    logic              slot_load;

    flush_index_walker #(
        .NUM_TLBS (NUM_TLBS),
        .NUM_WAYS (NUM_WAYS),
        .NUM_SETS (NUM_SETS)
    ) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (walk_clear),
        .step_i  (walk_step),
        .tlb_o   (tlb_rd_sel_o),
        .way_o   (tlb_rd_way_o),
        .set_o   (tlb_rd_set_o),
        .last_o  (walk_last)
    );

    flush_entry_judge #(
        .PID_W      (PID_W),
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_judge (
        .hi_i        (tlb_rd_hi_i),
        .lo_i        (tlb_rd_lo_i),
        .pid_i       (pid_q),
        .hit_o       (entry_hit),
        .page_addr_o (entry_addr)
    );

    flush_req_slot #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (slot_load),
        .addr_i  (entry_addr),
        .ready_i (flush_ready_i),
        .valid_o (flush_valid_o),
        .addr_o  (flush_addr_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Process ID is captured only when a walk begins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q <= '0;
        end else if (state_q == SC_IDLE && start_i) begin
            pid_q <= pid_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE:  if (start_i) state_d = SC_FETCH;
            SC_FETCH: state_d = SC_JUDGE;
            SC_JUDGE: begin
                if (entry_hit)      state_d = SC_OFFER;
                else if (walk_last) state_d = SC_DONE;
                else                state_d = SC_FETCH;
            end
            SC_OFFER: begin
                if (flush_ready_i) state_d = walk_last ? SC_DONE : SC_FETCH;
            end
            SC_DONE:  state_d = SC_IDLE;
            default:  state_d = SC_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        tlb_rd_en_o = 1'b0;
        walk_clear  = 1'b0;
        walk_step   = 1'b0;
        slot_load   = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            SC_IDLE:  walk_clear  = start_i;
            SC_FETCH: tlb_rd_en_o = 1'b1;
            SC_JUDGE: begin
                slot_load = entry_hit;
                walk_step = !entry_hit && !walk_last;
            end
            SC_OFFER: walk_step = flush_ready_i && !walk_last;
            SC_DONE:  done_o    = 1'b1;
            default:  ;
        endcase
    end

    // R6
    no_read_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tlb_rd_en_o && flush_valid_o));

    // R6
    offer_matches_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_OFFER) == flush_valid_o);

    // R8
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    pid_held_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SC_IDLE) |=> $stable(pid_q));

    // R7
    start_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_JUDGE && start_i && !entry_hit && !walk_last) |=>
            (state_q == SC_FETCH && !(tlb_rd_sel_o == '0 && tlb_rd_way_o == '0 && tlb_rd_set_o == '0)));

endmodule

// File: tb/pid_flush_scanner_test.sv
module pid_flush_scanner_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  pid_i = '0;
    logic        tlb_rd_en_o;
    logic [0:0]  tlb_rd_sel_o;
    logic [1:0]  tlb_rd_way_o;
    logic [3:0]  tlb_rd_set_o;
    logic [31:0] tlb_rd_hi_i = '0;
    logic [31:0] tlb_rd_lo_i = '0;
    logic        flush_valid_o;
    logic        flush_ready_i = 1'b0;
    logic [31:0] flush_addr_o;
    logic        done_o;

    always #2 clk = ~clk;

    pid_flush_scanner uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .pid_i         (pid_i),
        .tlb_rd_en_o   (tlb_rd_en_o),
        .tlb_rd_sel_o  (tlb_rd_sel_o),
        .tlb_rd_way_o  (tlb_rd_way_o),
        .tlb_rd_set_o  (tlb_rd_set_o),
        .tlb_rd_hi_i   (tlb_rd_hi_i),
        .tlb_rd_lo_i   (tlb_rd_lo_i),
        .flush_valid_o (flush_valid_o),
        .flush_ready_i (flush_ready_i),
        .flush_addr_o  (flush_addr_o),
        .done_o        (done_o)
    );

    logic [31:0] hi_mem [0:127];
    logic [31:0] lo_mem [0:127];
    logic [31:0] exp_q [$];
    bit          seen [0:127];
    int          checks = 0;
    int          fails = 0;
    int          rd_count = 0;
    int          exp_rd_idx = 0;
    int          done_count = 0;
    int          ready_mode = 0;
    bit          prev_pending = 0;
    bit          prev_done = 0;
    logic [31:0] prev_addr = '0;
    logic [15:0] rdy_lfsr = 16'hACE1;
    int          cyc = 0;

    // TLB array model: data one cycle after strobe
    always_ff @(posedge clk) begin
        if (tlb_rd_en_o) begin
            tlb_rd_hi_i <= hi_mem[{tlb_rd_sel_o, tlb_rd_way_o, tlb_rd_set_o}];
            tlb_rd_lo_i <= lo_mem[{tlb_rd_sel_o, tlb_rd_way_o, tlb_rd_set_o}];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit qualifies(input logic [31:0] hi, input logic [31:0] lo, input logic [7:0] pid);
        return lo[3] && !lo[4] && ((hi[7:0] == pid) || lo[2]);
    endfunction

    // Ready driver, changes just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            rdy_lfsr = {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
            case (ready_mode)
                0: flush_ready_i = 1'b1;
                1: flush_ready_i = rdy_lfsr[0];
                default: flush_ready_i = (cyc % 23 == 0);
            endcase
        end
    end

    // Monitor: compares design output against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (tlb_rd_en_o) begin
                    check(!flush_valid_o, "R6 read while pending", 32'(flush_valid_o), 32'd0);
                    check({tlb_rd_sel_o, tlb_rd_way_o, tlb_rd_set_o} == 7'(exp_rd_idx), "R3 scan order",
                          32'({tlb_rd_sel_o, tlb_rd_way_o, tlb_rd_set_o}), 32'(exp_rd_idx));
                    exp_rd_idx++;
                    rd_count++;
                end
                if (flush_valid_o) begin
                    if (prev_pending)
                        check(flush_addr_o == prev_addr, "R6 address held", flush_addr_o, prev_addr);
                    if (flush_ready_i) begin
                        check(flush_addr_o[12:0] == 13'd0, "R5 page aligned", flush_addr_o, {flush_addr_o[31:13], 13'd0});
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R4 unexpected flush", flush_addr_o, 32'd0);
                        end else begin
                            logic [31:0] e;
                            e = exp_q.pop_front();
                            check(flush_addr_o == e, "R4 flush address", flush_addr_o, e);
                        end
                        seen[flush_addr_o[19:13]] = 1'b1;
                    end
                end
                prev_pending = flush_valid_o && !flush_ready_i;
                prev_addr    = flush_addr_o;
                if (done_o) begin
                    done_count++;
                    check(!prev_done, "R8 done width", 32'd1, 32'd0);
                end
                prev_done = done_o;
            end
        end
    end

    task automatic run_scan(input logic [7:0] pid, input int mode, input bit disturb);
        for (int i = 0; i < 128; i++) begin
            seen[i] = 1'b0;
            if (qualifies(hi_mem[i], lo_mem[i], pid))
                exp_q.push_back({hi_mem[i][31:13], 13'd0});
        end
        exp_rd_idx = 0;
        rd_count   = 0;
        done_count = 0;
        ready_mode = mode;
        @(negedge clk);
        pid_i   = pid;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            repeat (40) @(negedge clk);
            pid_i   = ~pid;   // R2: must not affect this walk
            start_i = 1'b1;   // R7: ignored while busy
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_count == 0) @(negedge clk);
        check(exp_q.size() == 0, "R4 missing flushes", 32'(exp_q.size()), 32'd0);
        check(rd_count == 128, "R3 read count", 32'(rd_count), 32'd128);
        check(!seen[3], "R9 global kept", 32'(seen[3]), 32'd0);
        check(seen[5], "R4 kernel foreign pid flushed", 32'(seen[5]), 32'd1);
        check(!seen[6], "R4 invalid kept", 32'(seen[6]), 32'd0);
        repeat (8) @(negedge clk);
        check(done_count == 1, "R8 single done", 32'(done_count), 32'd1);
        check(rd_count == 128, "R7 no restart", 32'(rd_count), 32'd128);
        exp_q.delete();
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            logic [7:0] epid;
            epid = (i % 3 == 0) ? 8'h5A : (i % 3 == 1) ? 8'hA5 : 8'(i * 7);
            hi_mem[i] = {12'(i * 37 + 5), 7'(i), 5'h1F, epid};
            lo_mem[i] = {19'(i * 11), 8'h00, (i % 7 == 2), (i % 5 != 0), (i % 13 == 9), 2'b11};
        end
        hi_mem[3][7:0] = 8'h5A; lo_mem[3][4:2] = 3'b111;   // global, valid, kernel
        hi_mem[5][7:0] = 8'h11; lo_mem[5][4:2] = 3'b011;   // kernel, foreign pid
        hi_mem[6][7:0] = 8'h5A; lo_mem[6][4:2] = 3'b000;   // invalid, matching pid

        repeat (3) @(negedge clk);
        check(!tlb_rd_en_o && !flush_valid_o && !done_o, "R1 in reset",
              {29'd0, tlb_rd_en_o, flush_valid_o, done_o}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!tlb_rd_en_o && !flush_valid_o && !done_o, "R1 idle after reset",
              {29'd0, tlb_rd_en_o, flush_valid_o, done_o}, 32'd0);

        run_scan(8'h5A, 0, 1'b0);
        run_scan(8'hA5, 1, 1'b1);
        run_scan(8'h3C, 2, 1'b0);
        run_scan(8'h5A, 1, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule